// File: doc/BRIEF.md
# Contactless select-answer responder

This block sits behind the framing layer of a contactless tag. It takes one received host frame at a time as a byte stream, where each byte carries a start marker and an end marker. When a frame is exactly the select-answer request, it checks the request's trailing CRC and splits the parameter byte into two fields. The upper field is a size index, which the block converts through a lookup table into the largest frame the host can receive. The lower field is the device identifier.

When the request is valid, the block presents the decoded size and identifier on its outputs with a one-cycle strobe. It then sends a fixed seven-byte answer on a valid/ready byte stream. The block works out the answer's CRC itself while the answer bytes go out. It sends no answer at all for frames that are malformed, oversize, reserved or corrupted. It also ignores any frame that starts while an answer is still going out.

Top module: `tag_select_responder`

## Requirements
- R1: A frame is accepted only when it holds exactly 4 bytes and its first byte is 0xE0. A frame with any other first byte gives no answer.
- R2: The CRC is CRC-16 with the reflected polynomial 0x8408. The register is preset to 0x6363, each byte enters least significant bit first, and there is no final inversion. The CRC is carried low byte first. A frame whose last two bytes are not the CRC of the bytes before them gives no answer.
- R3: Bits 7..4 of the second byte are the size index. The index maps to a size as follows: 0→16, 1→24, 2→32, 3→40, 4→48, 5→64, 6→96, 7→128, 8→256, 15→256.
- R4: Bits 3..0 of the second byte are the identifier. A frame gives no answer if its identifier is 15 or its size index is between 9 and 14.
- R5: The answer is the bytes 0x05, 0x78, 0x00, the timing parameter (default 0x50), 0x02, then the CRC low byte and the CRC high byte. The CRC is computed over the first five bytes as in R2. outLast is high only on the seventh byte.
- R6: A frame whose length is not 4 gives no answer. This includes frames longer than 256 bytes, which must not alias to a legal length.
- R7: For an accepted request, cfgStrobe is high for exactly one cycle, in the first cycle of the answer. In that cycle maxSize and devId show the decoded values, and they hold those values afterwards.
- R8: While outValid is high and outReady is low, outData and outValid stay unchanged.
- R9: Input bytes that arrive while an answer is pending or being sent are ignored. No second answer results from them.
- R10: After reset, outValid and cfgStrobe are low, and maxSize and devId are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input byte present |
| inData | input | 8 | Input byte |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| outValid | output | 1 | Answer byte present |
| outReady | input | 1 | Consumer takes the answer byte |
| outData | output | 8 | Answer byte |
| outLast | output | 1 | Answer byte is the final one |
| cfgStrobe | output | 1 | One-cycle pulse on a new accepted request |
| maxSize | output | 9 | Decoded host maximum frame size in bytes |
| devId | output | 4 | Decoded device identifier |

## Verification
The bench walks every legal size index, two reserved indices, identifier 15, and a request with a corrupted CRC. For each one it checks either the full answer with its CRC or complete silence. A table that is off by one entry, or one that accepts reserved codes, shows up as a wrong maxSize or as an answer where none is due. A frame of 260 bytes with a valid CRC catches a byte counter that wraps to 4 instead of saturating, because such a counter would answer the frame. Stalling outReady while a second frame arrives catches two faults: data that changes under backpressure, and a responder that restarts and sends a second answer.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_CHECK,
    ST_SEND
  } tsrState_t;

  typedef struct packed {
    logic startFrame;
    logic takeByte;
    logic latchCfg;
    logic txStart;
    logic txAdvance;
  } tsrCtl_t;

  localparam logic [7:0]  CMD_SELECT   = 8'hE0;
  localparam logic [7:0]  ANS_LEN      = 8'h05;
  localparam logic [7:0]  ANS_FORMAT   = 8'h78;
  localparam logic [7:0]  ANS_RATES    = 8'h00;
  localparam logic [7:0]  ANS_OPTION   = 8'h02;
  localparam int          ANS_BYTES    = 7;
  localparam int          ANS_BODY     = 5;
  localparam int          CMD_BYTES    = 4;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;

  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] dataIn);
    logic [15:0] r;
    r = crcIn ^ {8'h00, dataIn};
    for (int k = 0; k < 8; k++) begin
      if (r[0]) r = (r >> 1) ^ CRC_POLY_REF;
      else      r = r >> 1;
    end
    return r;
  endfunction

  // returns {legal, size}
  function automatic logic [9:0] sizeLookup(input logic [3:0] idx);
    logic [9:0] res;
    case (idx)
      4'd0:    res = {1'b1, 9'd16};
      4'd1:    res = {1'b1, 9'd24};
      4'd2:    res = {1'b1, 9'd32};
      4'd3:    res = {1'b1, 9'd40};
      4'd4:    res = {1'b1, 9'd48};
      4'd5:    res = {1'b1, 9'd64};
      4'd6:    res = {1'b1, 9'd96};
      4'd7:    res = {1'b1, 9'd128};
      4'd8:    res = {1'b1, 9'd256};
      4'd15:   res = {1'b1, 9'd256};
      default: res = {1'b0, 9'd0};
    endcase
    return res;
  endfunction

endpackage

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int          MAX_FRAME   = 256,
  parameter logic [7:0]  TIMING_BYTE = 8'h50,
  parameter logic [15:0] CRC_PRESET  = 16'h6363
) (
  input  logic       clk,
  input  logic       rstN,
  input  tsrCtl_t    ctl,
  input  logic [7:0] inData,
  output logic       frameOk,
  output logic [7:0] txByte,
  output logic       txLast,
  output logic       cfgStrobe,
  output logic [8:0] maxSize,
  output logic [3:0] devId
);

  localparam int CNT_W = $clog2(MAX_FRAME + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_FRAME + 1);
  localparam int IDX_W = $clog2(ANS_BYTES);

  logic [CNT_W-1:0] byteCnt;
  logic [7:0]       firstByte;
  logic [7:0]       paramByte;
  logic [15:0]      rxCrc;
  logic [IDX_W-1:0] txIdx;
  logic [15:0]      txCrc;
  logic [9:0]       sizeInfo;

  assign sizeInfo = sizeLookup(paramByte[7:4]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt   <= '0;
      firstByte <= '0;
      paramByte <= '0;
      rxCrc     <= CRC_PRESET;
    end else if (ctl.startFrame) begin
      byteCnt   <= CNT_W'(1);
      firstByte <= inData;
      paramByte <= '0;
      rxCrc     <= crcStep(CRC_PRESET, inData);
    end else if (ctl.takeByte) begin
      if (byteCnt != CNT_SAT) byteCnt <= byteCnt + CNT_W'(1);
      if (byteCnt == CNT_W'(1)) paramByte <= inData;
      rxCrc <= crcStep(rxCrc, inData);
    end
  end

  // residue of a reflected CRC with no final inversion over data plus its CRC is zero
  assign frameOk = (byteCnt == CNT_W'(CMD_BYTES)) && (firstByte == CMD_SELECT) &&
                   (rxCrc == 16'h0000) && sizeInfo[9] && (paramByte[3:0] != 4'hF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxSize   <= '0;
      devId     <= '0;
      cfgStrobe <= 1'b0;
    end else begin
      cfgStrobe <= ctl.latchCfg;
      if (ctl.latchCfg) begin
        maxSize <= sizeInfo[8:0];
        devId   <= paramByte[3:0];
      end
    end
  end

  always_comb begin
    case (txIdx)
      IDX_W'(0): txByte = ANS_LEN;
      IDX_W'(1): txByte = ANS_FORMAT;
      IDX_W'(2): txByte = ANS_RATES;
      IDX_W'(3): txByte = TIMING_BYTE;
      IDX_W'(4): txByte = ANS_OPTION;
      IDX_W'(5): txByte = txCrc[7:0];
      default:   txByte = txCrc[15:8];
    endcase
  end

  assign txLast = (txIdx == IDX_W'(ANS_BYTES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIdx <= '0;
      txCrc <= CRC_PRESET;
    end else if (ctl.txStart) begin
      txIdx <= '0;
      txCrc <= CRC_PRESET;
    end else if (ctl.txAdvance) begin
      txIdx <= txIdx + IDX_W'(1);
      if (txIdx < IDX_W'(ANS_BODY)) txCrc <= crcStep(txCrc, txByte);
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |=> !cfgStrobe); // R7
  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> (devId != 4'hF && maxSize >= 9'd16)); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchCfg |=> $stable(maxSize) && $stable(devId)); // R7

endmodule

// File: rtl/tsr_control.sv
module tsr_control
  import tsr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inSof,
  input  logic    inEof,
  input  logic    frameOk,
  input  logic    txLast,
  input  logic    outReady,
  output tsrCtl_t ctl,
  output logic    sending
);

  tsrState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (inValid && inSof) begin
          ctl.startFrame = 1'b1;
          nextState = inEof ? ST_CHECK : ST_RECV;
        end
      end
      ST_RECV: begin
        if (inValid) begin
          if (inSof) ctl.startFrame = 1'b1;
          else       ctl.takeByte   = 1'b1;
          if (inEof) nextState = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (frameOk) begin
          ctl.latchCfg = 1'b1;
          ctl.txStart  = 1'b1;
          nextState    = ST_SEND;
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: begin
        if (outReady) begin
          ctl.txAdvance = 1'b1;
          if (txLast) nextState = ST_IDLE;
        end
      end
    endcase
  end

  assign sending = (state == ST_SEND);

  AST_SEND_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && outReady && txLast) |=> state == ST_IDLE); // R5
  AST_SEND_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !(outReady && txLast)) |=> state == ST_SEND); // R9
  AST_CHECK_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_CHECK |=> state != ST_CHECK); // R1

endmodule

// File: rtl/tag_select_responder.sv
module tag_select_responder
  import tsr_pkg::*;
#(
  parameter int          MAX_FRAME   = 256,
  parameter logic [7:0]  TIMING_BYTE = 8'h50,
  parameter logic [15:0] CRC_PRESET  = 16'h6363
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inSof,
  input  logic       inEof,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       cfgStrobe,
  output logic [8:0] maxSize,
  output logic [3:0] devId
);

  tsrCtl_t ctl;
  logic    frameOk;
  logic    txLast;
  logic    sending;

  tsr_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSof    (inSof),
    .inEof    (inEof),
    .frameOk  (frameOk),
    .txLast   (txLast),
    .outReady (outReady),
    .ctl      (ctl),
    .sending  (sending)
  );

  tsr_datapath #(
    .MAX_FRAME   (MAX_FRAME),
    .TIMING_BYTE (TIMING_BYTE),
    .CRC_PRESET  (CRC_PRESET)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inData    (inData),
    .frameOk   (frameOk),
    .txByte    (outData),
    .txLast    (txLast),
    .cfgStrobe (cfgStrobe),
    .maxSize   (maxSize),
    .devId     (devId)
  );

  assign outValid = sending;
  assign outLast  = sending && txLast;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData) && $stable(outLast)); // R8
  AST_STROBE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> (outValid && outData == ANS_LEN)); // R7

endmodule

// File: tb/tb_tag_select_responder.sv
module tb_tag_select_responder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inSof = 1'b0;
  logic       inEof = 1'b0;
  logic       outReady = 1'b1;
  logic       outValid;
  logic [7:0] outData;
  logic       outLast;
  logic       cfgStrobe;
  logic [8:0] maxSize;
  logic [3:0] devId;

  int checks = 0;
  int failures = 0;

  logic [7:0] frameBuf [0:299];
  logic [7:0] respBuf  [0:15];
  int         respLastAt;
  int         strobeCount;
  logic [8:0] capSize;
  logic [3:0] capId;

  always #5 clk = ~clk;

  tag_select_responder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSof(inSof),
    .inEof(inEof), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .cfgStrobe(cfgStrobe), .maxSize(maxSize), .devId(devId)
  );

  // {param byte, crc intact, answer expected, expected size}
  localparam int NVEC = 14;
  localparam logic [18:0] VEC [0:NVEC-1] = '{
    {8'h00, 1'b1, 1'b1, 9'd16},
    {8'h1E, 1'b1, 1'b1, 9'd24},
    {8'h25, 1'b1, 1'b1, 9'd32},
    {8'h3A, 1'b1, 1'b1, 9'd40},
    {8'h44, 1'b1, 1'b1, 9'd48},
    {8'h53, 1'b1, 1'b1, 9'd64},
    {8'h67, 1'b1, 1'b1, 9'd96},
    {8'h78, 1'b1, 1'b1, 9'd128},
    {8'h8C, 1'b1, 1'b1, 9'd256},
    {8'hF1, 1'b1, 1'b1, 9'd256},
    {8'h92, 1'b1, 1'b0, 9'd0},
    {8'hE3, 1'b1, 1'b0, 9'd0},
    {8'h0F, 1'b1, 1'b0, 9'd0},
    {8'h50, 1'b0, 1'b0, 9'd0}
  };

  function automatic logic [15:0] tbCrc(input int n);
    logic [15:0] c;
    c = 16'h6363;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ frameBuf[i][k];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic appendCrc(input int n);
    logic [15:0] c;
    c = tbCrc(n);
    frameBuf[n]   = c[7:0];
    frameBuf[n+1] = c[15:8];
  endtask

  task automatic sendFrame(input int len);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = frameBuf[i];
      inSof   = (i == 0);
      inEof   = (i == len - 1);
      @(negedge clk);
    end
    inValid = 1'b0;
    inSof   = 1'b0;
    inEof   = 1'b0;
  endtask

  task automatic collect(output int n);
    n = 0;
    respLastAt = -1;
    strobeCount = 0;
    for (int c = 0; c < 30; c++) begin
      if (cfgStrobe) begin
        strobeCount++;
        capSize = maxSize;
        capId = devId;
      end
      if (outValid && outReady) begin
        if (n < 16) respBuf[n] = outData;
        if (outLast) respLastAt = n;
        n++;
      end
      @(negedge clk);
    end
  endtask

  task automatic checkAnswer(input int n, input logic [8:0] expSize, input logic [3:0] expId);
    logic [15:0] c;
    frameBuf[0] = 8'h05; frameBuf[1] = 8'h78; frameBuf[2] = 8'h00;
    frameBuf[3] = 8'h50; frameBuf[4] = 8'h02;
    c = tbCrc(5);
    check(n == 7, "R5 answer length", n, 7);
    if (n == 7) begin
      for (int i = 0; i < 5; i++)
        check(respBuf[i] == frameBuf[i], "R5 answer byte", respBuf[i], frameBuf[i]);
      check(respBuf[5] == c[7:0], "R5 crc low", respBuf[5], c[7:0]);
      check(respBuf[6] == c[15:8], "R5 crc high", respBuf[6], c[15:8]);
      check(respLastAt == 6, "R5 outLast position", respLastAt, 6);
    end
    check(strobeCount == 1, "R7 strobe count", strobeCount, 1);
    check(capSize == expSize, "R3 maxSize", capSize, expSize);
    check(capId == expId, "R4 devId", capId, expId);
  endtask

  task automatic checkSilent(input string req);
    int n;
    collect(n);
    check(n == 0, req, n, 0);
    check(strobeCount == 0, req, strobeCount, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(outValid == 1'b0, "R10 outValid", outValid, 0);
    check(cfgStrobe == 1'b0, "R10 cfgStrobe", cfgStrobe, 0);
    check(maxSize == 9'd0, "R10 maxSize", maxSize, 0);
    check(devId == 4'd0, "R10 devId", devId, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      frameBuf[0] = 8'hE0;
      frameBuf[1] = VEC[v][18:11];
      appendCrc(2);
      if (!VEC[v][10]) frameBuf[3] = frameBuf[3] ^ 8'h01;
      sendFrame(4);
      if (VEC[v][9]) begin
        collect(n);
        checkAnswer(n, VEC[v][8:0], VEC[v][14:11]);
      end else begin
        checkSilent("R4 R2 drop");
      end
    end

    // R1 wrong command byte, valid CRC
    frameBuf[0] = 8'hE1; frameBuf[1] = 8'h00; appendCrc(2);
    sendFrame(4);
    checkSilent("R1 wrong command");

    // R6 three-byte frame with a valid CRC
    frameBuf[0] = 8'hE0; appendCrc(1);
    sendFrame(3);
    checkSilent("R6 short frame");

    // R6 five-byte frame with a valid CRC
    frameBuf[0] = 8'hE0; frameBuf[1] = 8'h00; frameBuf[2] = 8'h11; appendCrc(3);
    sendFrame(5);
    checkSilent("R6 long frame");

    // R6 260-byte frame: a wrapping counter would see 4
    frameBuf[0] = 8'hE0; frameBuf[1] = 8'h80;
    for (int i = 2; i < 258; i++) frameBuf[i] = 8'(i);
    appendCrc(258);
    sendFrame(260);
    checkSilent("R6 oversize frame");

    // R8 R9 stall with a frame injected during the answer
    frameBuf[0] = 8'hE0; frameBuf[1] = 8'h32; appendCrc(2);
    outReady = 1'b0;
    sendFrame(4);
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b1, "R8 valid under stall", outValid, 1);
    held = outData;
    frameBuf[1] = 8'h45; appendCrc(2);
    sendFrame(4);
    check(outValid == 1'b1, "R8 valid held", outValid, 1);
    check(outData == held, "R8 data held", outData, held);
    outReady = 1'b1;
    collect(n);
    check(n == 7, "R9 single answer length", n, 7);
    check(maxSize == 9'd40 && devId == 4'd2, "R9 config unchanged", {maxSize, devId}, {9'd40, 4'd2});
    checkSilent("R9 no second answer");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule